// File: doc/BRIEF.md
# Packed-Access Byte FIFO Pair

This block sits between a host register port and a card-side byte stream. It holds two 32-byte circular queues: a transmit queue that the host fills and the card drains, and a receive queue that the card fills and the host drains. A single host access carries 1, 2 or 4 bytes. The first byte of an access always sits in the highest byte lane that the access covers.

A transfer begins with a one-cycle start pulse that carries a byte count and a direction. A down-counter tracks the bytes still to cross the card stream. When it reaches zero the block raises a data-done flag, and for a write transfer a program-done flag as well. Two service-request flags tell an interrupt or DMA router when the host should refill the transmit queue or empty the receive queue. Each flag drops for one cycle after the host access that serves it and is then raised again from the queue state.

Top module: `bytefifo_pack`

## Requirements
- R1: While `rst` is high at a clock edge, both queues empty, the count clears, and every output is 0 after that edge.
- R2: A host write of N bytes (size code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) enqueues lanes N-1 down to 0 in that order. Only as many bytes are taken as the transmit queue has free slots before the edge; the rest are dropped.
- R3: A host read of N bytes dequeues up to N bytes. The first goes to lane N-1, the next to lane N-2, and so on. Lanes that received no byte read 0, and lanes at N and above read 0. `host_rdata` updates one cycle after the read and holds until the next read.
- R4: Each queue holds at most 32 bytes. `card_rx_ready` is low while 32 bytes are queued, and a host write never grows the transmit queue beyond 32.
- R5: In a write transfer, `card_tx_valid` is high when bytes remain, the transmit queue is not empty, and at least one of these holds: the queue is full, it holds at least the remaining count, or drain permission is set. Bytes leave in queue order.
- R6: A `part_release` pulse, or a full transmit queue, grants drain permission. The permission clears on the edge after the transmit queue is seen empty. Without it, a partly filled queue smaller than the remaining count is held back.
- R7: In a read transfer, `card_rx_ready` is high while bytes remain and the receive queue has room. Each accepted card byte decrements the count. In a write transfer, each accepted transmit byte decrements it.
- R8: One edge after an active transfer's count reaches zero, `data_done` sets. `prog_done` also sets if the transfer is a write. Both stay set until the next start pulse clears them.
- R9: `rx_req` is 0 on the cycle after a host read. On any other cycle it shows whether the receive queue held data before the last edge.
- R10: `tx_req` is 0 on the cycle after a host write. On any other cycle it shows, as of before the last edge, whether an active write transfer had bytes remaining and the transmit queue had a free slot.
- R11: Once `card_tx_valid` is high without `card_tx_ready`, it stays high with unchanged `card_tx_data` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Start pulse for a transfer |
| xfer_len | input | 16 | Byte count of the transfer |
| xfer_wr | input | 1 | 1 = write (host to card), 0 = read |
| part_release | input | 1 | Grants drain permission to a partly filled transmit queue |
| host_wr | input | 1 | Host write strobe into the transmit queue |
| host_rd | input | 1 | Host read strobe from the receive queue |
| host_size | input | 2 | Access size code |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| card_tx_valid | output | 1 | Transmit byte available |
| card_tx_ready | input | 1 | Card takes the transmit byte |
| card_tx_data | output | 8 | Transmit byte |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_ready | output | 1 | Block accepts the card byte |
| card_rx_data | input | 8 | Card byte |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| data_done | output | 1 | Transfer count exhausted |
| prog_done | output | 1 | Write transfer count exhausted |

## Verification
The assertions rely on `xfer_start` arriving only when no transfer is active. A mid-transfer start would replace the count under a stalled transmit byte and break the hold property. The stimulus therefore issues a start only when the bench's own model reports the previous transfer finished. Size codes, including the code 3 alias, appear freely. Card handshakes are randomised on both sides, so full-queue stalls and empty-queue partial reads occur alongside the directed ordering and release cases.

// File: rtl/bytefifo_pkg.sv
`timescale 1ns/1ps
package bytefifo_pkg;

  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    SZ_ONE  = 2'd0,
    SZ_TWO  = 2'd1,
    SZ_FOUR = 2'd2,
    SZ_ALT4 = 2'd3
  } acc_size_e;

  // Bytes moved by one host access, capped at the port's lane count.
  function automatic int unsigned access_bytes(input logic [1:0] sz, input int unsigned lanes);
    int unsigned w;
    w = 32'd1 << sz;
    return (w > lanes) ? lanes : w;
  endfunction

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/bf_ring.sv
`timescale 1ns/1ps
module bf_ring #(
  parameter int DEPTH = 32,
  parameter int IN_L  = 4,
  parameter int OUT_L = 1,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int IN_NB  = $clog2(IN_L + 1),
  localparam int OUT_NB = $clog2(OUT_L + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [IN_NB-1:0]           push_n,
  input  logic [IN_L-1:0][7:0]       push_data,
  input  logic [OUT_NB-1:0]          pop_n,
  output logic [OUT_L-1:0][7:0]      peek,
  output logic [CNT_W-1:0]           count
);
  import bytefifo_pkg::*;

  byte_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  // Storage: up to IN_L consecutive slots written per cycle (caller limits to free space)
  always_ff @(posedge clk) begin
    for (int i = 0; i < IN_L; i++) begin
      if (IN_NB'(i) < push_n) begin
        mem[wr_ptr + PTR_W'(i)] <= push_data[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      rd_ptr <= rd_ptr + PTR_W'(pop_n);
      count  <= count + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  // Head window: OUT_L oldest bytes, oldest in lane 0
  for (genvar g = 0; g < OUT_L; g++) begin : g_peek
    assign peek[g] = mem[rd_ptr + PTR_W'(g)];
  end

endmodule

// File: rtl/bf_lanes.sv
`timescale 1ns/1ps
module bf_lanes #(
  parameter int LANES = 4,
  localparam int NB_W = $clog2(LANES + 1)
) (
  input  logic [NB_W-1:0]       n_bytes,
  input  logic [LANES-1:0][7:0] wdata,
  input  logic [NB_W-1:0]       rd_n,
  input  logic [LANES-1:0][7:0] rd_bytes,
  output logic [LANES-1:0][7:0] push_bytes,
  output logic [LANES-1:0][7:0] rdata
);

  // Byte i of the queue order maps to lane n_bytes-1-i on the host side.
  always_comb begin
    push_bytes = '0;
    rdata      = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [NB_W-1:0] lane;
      lane = n_bytes - NB_W'(i) - NB_W'(1);
      if (NB_W'(i) < n_bytes) begin
        push_bytes[i] = wdata[lane];
        if (NB_W'(i) < rd_n) begin
          rdata[lane] = rd_bytes[i];
        end
      end
    end
  end

endmodule

// File: rtl/bf_xfer.sv
`timescale 1ns/1ps
module bf_xfer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic             start_wr,
  input  logic             beat,
  input  logic             release_req,
  input  logic             tx_empty,
  input  logic             tx_full,
  output logic             active,
  output logic             wr_dir,
  output logic [LEN_W-1:0] left,
  output logic             released,
  output logic             data_done,
  output logic             prog_done
);

  logic finish;
  assign finish = active && (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      wr_dir    <= 1'b0;
      left      <= '0;
      data_done <= 1'b0;
      prog_done <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      wr_dir    <= start_wr;
      left      <= start_len;
      data_done <= 1'b0;
      prog_done <= 1'b0;
    end else begin
      if (finish) begin
        active    <= 1'b0;
        data_done <= 1'b1;
        if (wr_dir) prog_done <= 1'b1;
      end
      if (beat && (left != '0)) left <= left - LEN_W'(1);
    end
  end

  // Drain permit: granted by host release or a full queue, withdrawn once empty
  always_ff @(posedge clk) begin
    if (rst) released <= 1'b0;
    else if (release_req || tx_full) released <= 1'b1;
    else if (tx_empty) released <= 1'b0;
  end

endmodule

// File: rtl/bytefifo_pack.sv
`timescale 1ns/1ps
module bytefifo_pack
  import bytefifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int HOST_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_start,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_wr,
  input  logic              part_release,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_size,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              card_tx_valid,
  input  logic              card_tx_ready,
  output logic [7:0]        card_tx_data,
  input  logic              card_rx_valid,
  output logic              card_rx_ready,
  input  logic [7:0]        card_rx_data,
  output logic              rx_req,
  output logic              tx_req,
  output logic              data_done,
  output logic              prog_done
);
  localparam int LANES = HOST_W / 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NB_W  = $clog2(LANES + 1);

  logic [NB_W-1:0]        n_req;
  logic [NB_W-1:0]        tx_push_n;
  logic [NB_W-1:0]        rx_pop_n;
  logic [CNT_W-1:0]       tx_cnt;
  logic [CNT_W-1:0]       rx_cnt;
  logic [LANES-1:0][7:0]  tx_push_bytes;
  logic [LANES-1:0][7:0]  rx_peek;
  logic [LANES-1:0][7:0]  rdata_next;
  logic [0:0][7:0]        tx_peek;
  logic [0:0][7:0]        rx_in;
  logic                   tx_fire;
  logic                   rx_fire;
  logic                   x_active;
  logic                   x_wr;
  logic [LEN_W-1:0]       x_left;
  logic                   x_rel;
  logic                   tx_full;
  logic                   tx_drain_ok;

  // Access sizing against queue occupancy before the edge
  always_comb begin
    n_req     = NB_W'(access_bytes(host_size, LANES));
    tx_push_n = host_wr ? NB_W'(min_u(32'(n_req), DEPTH - 32'(tx_cnt))) : '0;
    rx_pop_n  = host_rd ? NB_W'(min_u(32'(n_req), 32'(rx_cnt))) : '0;
  end

  bf_lanes #(.LANES(LANES)) u_lanes (
    .n_bytes   (n_req),
    .wdata     (host_wdata),
    .rd_n      (rx_pop_n),
    .rd_bytes  (rx_peek),
    .push_bytes(tx_push_bytes),
    .rdata     (rdata_next)
  );

  assign tx_full     = (tx_cnt == CNT_W'(DEPTH));
  assign tx_drain_ok = tx_full || (32'(tx_cnt) >= 32'(x_left)) || x_rel;

  assign card_tx_valid = x_active && x_wr && (x_left != '0) && (tx_cnt != '0) && tx_drain_ok;
  assign card_tx_data  = tx_peek[0];
  assign card_rx_ready = x_active && !x_wr && (x_left != '0) && (rx_cnt != CNT_W'(DEPTH));
  assign tx_fire       = card_tx_valid && card_tx_ready;
  assign rx_fire       = card_rx_ready && card_rx_valid;
  assign rx_in[0]      = card_rx_data;

  bf_ring #(.DEPTH(DEPTH), .IN_L(LANES), .OUT_L(1)) u_txq (
    .clk      (clk),
    .rst      (rst),
    .push_n   (tx_push_n),
    .push_data(tx_push_bytes),
    .pop_n    (tx_fire),
    .peek     (tx_peek),
    .count    (tx_cnt)
  );

  bf_ring #(.DEPTH(DEPTH), .IN_L(1), .OUT_L(LANES)) u_rxq (
    .clk      (clk),
    .rst      (rst),
    .push_n   (rx_fire),
    .push_data(rx_in),
    .pop_n    (rx_pop_n),
    .peek     (rx_peek),
    .count    (rx_cnt)
  );

  bf_xfer #(.LEN_W(LEN_W)) u_xfer (
    .clk        (clk),
    .rst        (rst),
    .start      (xfer_start),
    .start_len  (xfer_len),
    .start_wr   (xfer_wr),
    .beat       (tx_fire || rx_fire),
    .release_req(part_release),
    .tx_empty   (tx_cnt == '0),
    .tx_full    (tx_full),
    .active     (x_active),
    .wr_dir     (x_wr),
    .left       (x_left),
    .released   (x_rel),
    .data_done  (data_done),
    .prog_done  (prog_done)
  );

  // Registered host data and service requests
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      rx_req     <= 1'b0;
      tx_req     <= 1'b0;
    end else begin
      if (host_rd) host_rdata <= rdata_next;
      rx_req <= !host_rd && (rx_cnt != '0);
      tx_req <= !host_wr && x_active && x_wr && (x_left != '0) && !tx_full;
    end
  end

endmodule

// File: rtl/bytefifo_pack_chk.sv
`timescale 1ns/1ps
module bytefifo_pack_chk #(
  parameter int DEPTH  = 32,
  parameter int HOST_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_start,
  input logic              host_rd,
  input logic              host_wr,
  input logic [HOST_W-1:0] host_rdata,
  input logic              card_tx_valid,
  input logic              card_tx_ready,
  input logic [7:0]        card_tx_data,
  input logic              card_rx_ready,
  input logic              rx_req,
  input logic              tx_req,
  input logic              data_done,
  input logic              prog_done,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt
);

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

  // R4
  rx_full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == CNT_W'(DEPTH)) |-> !card_rx_ready);

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (card_tx_valid && !card_tx_ready && !xfer_start) |=> (card_tx_valid && $stable(card_tx_data)));

  // R9
  rx_req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> !rx_req);

  // R10
  tx_req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> !tx_req);

  // R8
  prog_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    prog_done |-> data_done);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (data_done && !xfer_start) |=> data_done);

  // R3
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && (rx_cnt == '0)) |=> (host_rdata == '0));

  // R7
  one_direction_chk: assert property (@(posedge clk) disable iff (rst)
    card_tx_valid |-> !card_rx_ready);

endmodule

bind bytefifo_pack bytefifo_pack_chk #(.DEPTH(DEPTH), .HOST_W(HOST_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .xfer_start   (xfer_start),
  .host_rd      (host_rd),
  .host_wr      (host_wr),
  .host_rdata   (host_rdata),
  .card_tx_valid(card_tx_valid),
  .card_tx_ready(card_tx_ready),
  .card_tx_data (card_tx_data),
  .card_rx_ready(card_rx_ready),
  .rx_req       (rx_req),
  .tx_req       (tx_req),
  .data_done    (data_done),
  .prog_done    (prog_done),
  .tx_cnt       (tx_cnt),
  .rx_cnt       (rx_cnt)
);

// File: tb/test_bytefifo_pack.sv
`timescale 1ns/1ps
module test_bytefifo_pack;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xfer_start = 1'b0;
  logic [15:0] xfer_len = '0;
  logic        xfer_wr = 1'b0;
  logic        part_release = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        card_tx_valid;
  logic        card_tx_ready = 1'b0;
  logic [7:0]  card_tx_data;
  logic        card_rx_valid = 1'b0;
  logic        card_rx_ready;
  logic [7:0]  card_rx_data;
  logic        rx_req, tx_req, data_done, prog_done;

  always #10 clk = ~clk;

  bytefifo_pack i_bytefifo_pack (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_len(xfer_len), .xfer_wr(xfer_wr),
    .part_release(part_release), .host_wr(host_wr), .host_rd(host_rd), .host_size(host_size),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .card_tx_valid(card_tx_valid),
    .card_tx_ready(card_tx_ready), .card_tx_data(card_tx_data), .card_rx_valid(card_rx_valid),
    .card_rx_ready(card_rx_ready), .card_rx_data(card_rx_data), .rx_req(rx_req), .tx_req(tx_req),
    .data_done(data_done), .prog_done(prog_done)
  );

  int total = 0;
  int bad = 0;
  bit cmp_en = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  byte unsigned txq[$];
  byte unsigned rxq[$];
  byte unsigned sent[$];
  int  m_left = 0;
  bit  m_active = 0, m_wr = 0, m_rel = 0, m_dd = 0, m_pd = 0, m_rxreq = 0, m_txreq = 0;
  logic [31:0] m_rdata = '0;
  bit  m_hold = 0;
  byte unsigned m_hold_data = 0;
  logic [7:0] feed = 8'h10;
  int  cyc = 0;

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction
  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
  function automatic bit m_txv();
    int c;
    c = txq.size();
    return m_active && m_wr && (m_left != 0) && (c != 0) && (c == DEPTH || c >= m_left || m_rel);
  endfunction
  function automatic bit m_rxr();
    return m_active && !m_wr && (m_left != 0) && (rxq.size() < DEPTH);
  endfunction

  assign card_rx_data = feed;

  always @(posedge clk) begin
    int txc, rxc, n, k;
    bit tv, rr, evt;
    logic [31:0] rd;
    cyc++;
    if (card_tx_valid && card_tx_ready) sent.push_back(card_tx_data);
    if (xfer_start) feed <= 8'h10;
    else if (card_rx_valid && card_rx_ready) feed <= feed + 8'd1;
    if (rst) begin
      txq.delete(); rxq.delete();
      m_left = 0; m_active = 0; m_wr = 0; m_rel = 0; m_dd = 0; m_pd = 0;
      m_rxreq = 0; m_txreq = 0; m_rdata = '0; m_hold = 0;
    end else begin
      txc = txq.size();
      rxc = rxq.size();
      tv  = m_txv();
      rr  = m_rxr();
      evt = m_active && (m_left == 0);
      n   = nbytes(host_size);
      m_hold = tv && !card_tx_ready;
      if (m_hold) m_hold_data = txq[0];
      m_rxreq = !host_rd && (rxc != 0);
      m_txreq = !host_wr && m_active && m_wr && (m_left != 0) && (txc < DEPTH);
      if (host_rd) begin
        k = mn(n, rxc);
        rd = '0;
        for (int i = 0; i < k; i++) rd[(n-1-i)*8 +: 8] = rxq.pop_front();
        m_rdata = rd;
      end
      if (rr && card_rx_valid) rxq.push_back(card_rx_data);
      if (tv && card_tx_ready) void'(txq.pop_front());
      if (host_wr) begin
        k = mn(n, DEPTH - txc);
        for (int i = 0; i < k; i++) txq.push_back(host_wdata[(n-1-i)*8 +: 8]);
      end
      if (part_release || txc == DEPTH) m_rel = 1;
      else if (txc == 0) m_rel = 0;
      if (xfer_start) begin
        m_active = 1; m_wr = xfer_wr; m_left = xfer_len; m_dd = 0; m_pd = 0;
      end else begin
        if (evt) begin m_active = 0; m_dd = 1; if (m_wr) m_pd = 1; end
        if ((tv && card_tx_ready) || (rr && card_rx_valid)) m_left--;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk(card_tx_valid == m_txv(), "R5", "tx_valid", card_tx_valid, m_txv());
      if (m_txv()) chk(card_tx_data == txq[0], "R5", "tx_data", card_tx_data, txq[0]);
      chk(card_rx_ready == m_rxr(), "R7", "rx_ready", card_rx_ready, m_rxr());
      chk(host_rdata == m_rdata, "R3", "rdata", host_rdata, m_rdata);
      chk(rx_req == m_rxreq, "R9", "rx_req", rx_req, m_rxreq);
      chk(tx_req == m_txreq, "R10", "tx_req", tx_req, m_txreq);
      chk(data_done == m_dd, "R8", "data_done", data_done, m_dd);
      chk(prog_done == m_pd, "R8", "prog_done", prog_done, m_pd);
      if (m_hold) chk(card_tx_valid && card_tx_data == m_hold_data, "R11", "hold",
                      {card_tx_valid, card_tx_data}, {1'b1, m_hold_data});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int k = 1);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask
  task automatic start(input int len, input bit wr);
    xfer_start = 1; xfer_len = 16'(len); xfer_wr = wr;
    step(); xfer_start = 0;
  endtask
  task automatic hwrite(input logic [1:0] sz, input logic [31:0] d);
    host_wr = 1; host_size = sz; host_wdata = d;
    step(); host_wr = 0;
  endtask
  task automatic hread(input logic [1:0] sz);
    host_rd = 1; host_size = sz;
    step(); host_rd = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    @(negedge clk);
    while (cyc < 150000) @(negedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 0;
    cmp_en = 1;
    step();
    // R1: reset state
    chk({card_tx_valid, card_rx_ready, rx_req, tx_req, data_done, prog_done} == 6'b0,
        "R1", "flags after reset", {card_tx_valid, card_rx_ready, rx_req, tx_req, data_done, prog_done}, 0);
    chk(host_rdata == 0, "R1", "rdata after reset", host_rdata, 0);

    // R2/R5: packing order, drain once queue covers remaining count
    card_tx_ready = 1; sent.delete();
    start(7, 1);
    hwrite(2'd2, 32'hA1A2A3A4);
    hwrite(2'd1, 32'h0000B1B2);
    chk(sent.size() == 0, "R5", "held while short of count", sent.size(), 0);
    hwrite(2'd0, 32'h000000C1);
    step(12);
    chk(sent.size() == 7, "R2", "bytes sent", sent.size(), 7);
    if (sent.size() == 7) begin
      chk({sent[0], sent[1], sent[2], sent[3]} == 32'hA1A2A3A4, "R2", "word order",
          {sent[0], sent[1], sent[2], sent[3]}, 32'hA1A2A3A4);
      chk({sent[4], sent[5], sent[6]} == 24'hB1B2C1, "R2", "half/byte order",
          {sent[4], sent[5], sent[6]}, 24'hB1B2C1);
    end
    chk(data_done && prog_done, "R8", "write done flags", {data_done, prog_done}, 2'b11);

    // R6: partial release
    sent.delete();
    start(8, 1);
    hwrite(2'd2, 32'h11223344);
    step(5);
    chk(sent.size() == 0, "R6", "partial held", sent.size(), 0);
    chk(data_done == 0, "R8", "cleared by start", data_done, 0);
    part_release = 1; step(); part_release = 0;
    step(8);
    chk(sent.size() == 4, "R6", "released bytes", sent.size(), 4);
    hwrite(2'd3, 32'h55667788);
    step(10);
    chk(sent.size() == 8 && sent[7] == 8'h88, "R6", "tail after release", sent.size(), 8);

    // R4/R10: overfill the transmit queue
    sent.delete(); card_tx_ready = 0;
    start(40, 1);
    for (int w = 0; w < 9; w++)
      hwrite(2'd2, {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)});
    chk(card_tx_valid == 1, "R5", "full queue drains", card_tx_valid, 1);
    chk(tx_req == 0, "R10", "no request when full", tx_req, 0);
    step(3);
    card_tx_ready = 1;
    step(40);
    chk(sent.size() == 32, "R4", "32 bytes kept", sent.size(), 32);
    if (sent.size() == 32) chk(sent[31] == 8'd31, "R4", "last kept byte", sent[31], 31);
    hwrite(2'd2, 32'hE0E1E2E3);
    hwrite(2'd2, 32'hE4E5E6E7);
    step(12);
    chk(sent.size() == 40 && sent[39] == 8'hE7, "R2", "after overfill", sent.size(), 40);
    chk(data_done && prog_done, "R8", "write done", {data_done, prog_done}, 2'b11);

    // R3/R7/R9: read direction, unpacking, zero fill
    card_rx_valid = 1;
    start(6, 0);
    step(10);
    chk(rx_req == 1, "R9", "request with data", rx_req, 1);
    hread(2'd2);
    chk(host_rdata == 32'h10111213, "R3", "word read", host_rdata, 32'h10111213);
    chk(rx_req == 0, "R9", "dropped after read", rx_req, 0);
    hread(2'd0);
    chk(host_rdata == 32'h00000014, "R3", "byte read", host_rdata, 32'h14);
    hread(2'd1);
    chk(host_rdata == 32'h00001500, "R3", "short half read", host_rdata, 32'h1500);
    hread(2'd3);
    chk(host_rdata == 32'h0, "R3", "empty read", host_rdata, 0);
    chk(data_done && !prog_done, "R8", "read done flags", {data_done, prog_done}, 2'b10);

    // R4/R7: receive queue fills to 32
    start(40, 0);
    step(40);
    chk(card_rx_ready == 0, "R4", "rx stall at 32", card_rx_ready, 0);
    for (int w = 0; w < 10; w++) begin
      hread(2'd2);
      if (w == 0) chk(host_rdata == 32'h10111213, "R7", "first rx word", host_rdata, 32'h10111213);
      if (w == 9) chk(host_rdata == 32'h34353637, "R7", "last rx word", host_rdata, 32'h34353637);
      step(4);
    end
    chk(data_done == 1, "R8", "rx count done", data_done, 1);

    // Mixed random traffic checked against the model each cycle
    for (int c = 0; c < 6000; c++) begin
      if (!m_active && $urandom_range(0, 7) == 0) begin
        xfer_start = 1; xfer_len = 16'($urandom_range(0, 50)); xfer_wr = 1'($urandom_range(0, 1));
      end else xfer_start = 0;
      host_wr = ($urandom_range(0, 3) == 0);
      host_rd = ($urandom_range(0, 3) == 0);
      host_size = 2'($urandom_range(0, 3));
      host_wdata = $urandom;
      part_release = ($urandom_range(0, 15) == 0);
      card_tx_ready = 1'($urandom_range(0, 1));
      card_rx_valid = 1'($urandom_range(0, 1));
      step();
    end
    xfer_start = 0; host_wr = 0; host_rd = 0; part_release = 0;
    step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule